// File: doc/BRIEF.md
# PLL Calibration and Holdover Sequencer

This block is the control state machine that sits beside a clock-multiplying PLL. It decides when the analog side is told to run a self-calibration, when the output frequency must be parked at the bottom of its range, when the loop is allowed to acquire and hold lock, and when it must coast in digital hold because the reference has gone away. Calibration is done once per power-up or per release of the reset/calibrate pin. A later loss of reference leads to holdover and then a direct relock, with no new calibration.

The reset/calibrate pin and the reference-valid flag are asynchronous, so both pass through synchronisers. A loss of reference counts only once the synchronised flag has stayed low for `LOSS_LIMIT` consecutive cycles. The power-good flag acts as an asynchronous reset of all state. While the pin is held low, the block tri-states the single-ended outputs. It forces the differential outputs to a fixed level only when the frequency-select code is not zero.

Top module: `pll_cal_seq`

## Requirements
- R1: While `pwr_good` is low, the block is held in the reset state (state 0). After `pwr_good` rises with `rstcal_n` high and the reference valid, the block enters CALIBRATE on the 4th rising edge and pulses `cal_start`.
- R2: Once `rstcal_n` has been low for `SYNC_STAGES`+1 edges, the block is in reset from any state. When it returns high, a fresh calibration runs, even after an earlier one.
- R3: `se_tristate` is 1 exactly while the state is reset.
- R4: `diff_force` is 1 only in the reset state with `fsel` equal to 01, 10 or 11. With `fsel` = 00 it is 0.
- R5: After reset, the block waits in WAIT_CLK (state 1) while the reference is not valid, and `park_low` is 1 there only.
- R6: `cal_start` is a single-cycle pulse in the first cycle of each stay in CALIBRATE (state 2).
- R7: `cal_done` in CALIBRATE moves the block to ACQUIRE (state 3) on the next edge. `cal_done` in any other state has no effect.
- R8: In ACQUIRE, `lock_ind` high moves the block to LOCKED (state 4). In LOCKED, `lock_ind` low returns it to ACQUIRE.
- R9: A reference loss in ACQUIRE or LOCKED raises `hold_en` and enters HOLDOVER (state 5) exactly `SYNC_STAGES`+`LOSS_LIMIT`+1 edges after the flag falls. A loss shorter than `LOSS_LIMIT` synchronised cycles is ignored.
- R10: When the reference returns in HOLDOVER, the block goes to ACQUIRE after `SYNC_STAGES`+1 edges without asserting `cal_start`.
- R11: A reference loss during CALIBRATE returns the block to WAIT_CLK after `SYNC_STAGES`+1 edges.
- R12: `state_o` encodes reset=0, WAIT_CLK=1, CALIBRATE=2, ACQUIRE=3, LOCKED=4, HOLDOVER=5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| pwr_good | input | 1 | Power good; low resets everything asynchronously |
| rstcal_n | input | 1 | Reset/calibrate pin, active low, asynchronous |
| clk_valid | input | 1 | Reference clock present, asynchronous |
| cal_done | input | 1 | Calibration finished, from the analog side |
| lock_ind | input | 1 | Loop lock indicator |
| fsel | input | 2 | Frequency-select code |
| cal_start | output | 1 | One-cycle calibration start pulse |
| park_low | output | 1 | Request to park the output at the low frequency end |
| hold_en | output | 1 | Digital hold enable |
| se_tristate | output | 1 | Tri-state the single-ended outputs |
| diff_force | output | 1 | Force the differential outputs to a fixed level |
| state_o | output | 3 | Current state code |

## Verification
The hardest situation to reach is the difference between a true loss of reference and a short dropout, together with the return from holdover without a recalibration. Both need the loop first brought through calibration and lock. From LOCKED, the stimulus drops the reference for one cycle less than the persistence limit and confirms that nothing changes. It then drops the reference for good and counts edges to the exact holdover entry. Finally it restores the reference and watches that no calibration pulse appears on the way back to ACQUIRE.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [2:0] {
    ST_RESET = 3'd0,
    ST_WAIT  = 3'd1,
    ST_CAL   = 3'd2,
    ST_ACQ   = 3'd3,
    ST_LOCK  = 3'd4,
    ST_HOLD  = 3'd5
  } seq_state_e;

  // Differential outputs are forced in reset only for a non-zero select code.
  function automatic logic force_code(input logic [1:0] code);
    return code != 2'b00;
  endfunction

  // Saturating persistence count of a low reference flag.
  function automatic int unsigned next_loss_count(input int unsigned cnt,
                                                  input logic valid,
                                                  input int unsigned limit);
    if (valid) return 0;
    if (cnt >= limit) return limit;
    return cnt + 1;
  endfunction

endpackage

// File: rtl/pll_seq_sync.sv
module pll_seq_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) stg[0] <= '0;
          else         stg[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) stg[g] <= '0;
          else         stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/pll_seq_loss_filter.sv
module pll_seq_loss_filter #(
  parameter int LOSS_LIMIT = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic valid_s,
  output logic lost_o
);
  import pll_seq_pkg::*;

  localparam int CNT_W = $clog2(LOSS_LIMIT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = CNT_W'(next_loss_count(int'(cnt_q), valid_s, LOSS_LIMIT));
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign lost_o = (cnt_q >= CNT_W'(LOSS_LIMIT));

endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm (
  input  logic                    clk,
  input  logic                    arst_n,
  input  logic                    pin_s,
  input  logic                    valid_s,
  input  logic                    lost,
  input  logic                    cal_done,
  input  logic                    lock_ind,
  input  logic [1:0]              fsel,
  output pll_seq_pkg::seq_state_e state_o,
  output logic                    cal_start,
  output logic                    park_low,
  output logic                    hold_en,
  output logic                    se_tristate,
  output logic                    diff_force
);
  import pll_seq_pkg::*;

  seq_state_e cur_q, nxt;
  logic       start_q;

  always_comb begin
    nxt = cur_q;
    if (!pin_s) begin
      nxt = ST_RESET;
    end else begin
      case (cur_q)
        ST_RESET: nxt = ST_WAIT;
        ST_WAIT:  if (valid_s)  nxt = ST_CAL;
        ST_CAL:   if (!valid_s) nxt = ST_WAIT;
                  else if (cal_done) nxt = ST_ACQ;
        ST_ACQ:   if (lost)     nxt = ST_HOLD;
                  else if (lock_ind) nxt = ST_LOCK;
        ST_LOCK:  if (lost)     nxt = ST_HOLD;
                  else if (!lock_ind) nxt = ST_ACQ;
        ST_HOLD:  if (valid_s)  nxt = ST_ACQ;
        default:  nxt = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cur_q   <= ST_RESET;
      start_q <= 1'b0;
    end else begin
      cur_q   <= nxt;
      start_q <= (nxt == ST_CAL) && (cur_q != ST_CAL);
    end
  end

  assign state_o     = cur_q;
  assign cal_start   = start_q;
  assign park_low    = (cur_q == ST_WAIT);
  assign hold_en     = (cur_q == ST_HOLD);
  assign se_tristate = (cur_q == ST_RESET);
  assign diff_force  = (cur_q == ST_RESET) && force_code(fsel);

endmodule

// File: rtl/pll_cal_seq.sv
module pll_cal_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int LOSS_LIMIT  = 4
) (
  input  logic       clk,
  input  logic       pwr_good,
  input  logic       rstcal_n,
  input  logic       clk_valid,
  input  logic       cal_done,
  input  logic       lock_ind,
  input  logic [1:0] fsel,
  output logic       cal_start,
  output logic       park_low,
  output logic       hold_en,
  output logic       se_tristate,
  output logic       diff_force,
  output logic [2:0] state_o
);
  import pll_seq_pkg::*;

  logic [1:0] raw_in;
  logic [1:0] sync_out;
  logic       pin_sync;
  logic       valid_sync;
  logic       clk_lost;
  seq_state_e cur_state;

  assign raw_in     = {rstcal_n, clk_valid};
  assign pin_sync   = sync_out[1];
  assign valid_sync = sync_out[0];

  pll_seq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (pwr_good),
    .d_i    (raw_in),
    .q_o    (sync_out)
  );

  pll_seq_loss_filter #(.LOSS_LIMIT(LOSS_LIMIT)) u_loss (
    .clk     (clk),
    .arst_n  (pwr_good),
    .valid_s (valid_sync),
    .lost_o  (clk_lost)
  );

  pll_seq_fsm u_fsm (
    .clk         (clk),
    .arst_n      (pwr_good),
    .pin_s       (pin_sync),
    .valid_s     (valid_sync),
    .lost        (clk_lost),
    .cal_done    (cal_done),
    .lock_ind    (lock_ind),
    .fsel        (fsel),
    .state_o     (cur_state),
    .cal_start   (cal_start),
    .park_low    (park_low),
    .hold_en     (hold_en),
    .se_tristate (se_tristate),
    .diff_force  (diff_force)
  );

  assign state_o = cur_state;

endmodule

// File: rtl/pll_cal_seq_chk.sv
module pll_cal_seq_chk (
  input logic       clk,
  input logic       pwr_good,
  input logic [2:0] state_o,
  input logic       cal_start,
  input logic       park_low,
  input logic       hold_en,
  input logic       se_tristate,
  input logic       diff_force,
  input logic       pin_s,
  input logic       clk_lost
);

  // R2
  pin_low_reset_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    !pin_s |=> (state_o == 3'd0));

  // R6
  start_single_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    cal_start |=> !cal_start);

  // R6
  start_in_cal_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    cal_start |-> (state_o == 3'd2));

  // R9
  hold_after_loss_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(hold_en) |-> $past(clk_lost));

  // R10
  hold_exit_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    (state_o == 3'd5) |=> (state_o == 3'd5 || state_o == 3'd3 || state_o == 3'd0));

  // R7
  wait_no_acq_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    (state_o == 3'd1) |=> (state_o != 3'd3));

  // R4
  force_in_reset_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    diff_force |-> se_tristate);

  // R5
  park_exclusive_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    park_low |-> (!hold_en && !se_tristate && !cal_start));

endmodule

bind pll_cal_seq pll_cal_seq_chk chk_i (
  .clk         (clk),
  .pwr_good    (pwr_good),
  .state_o     (state_o),
  .cal_start   (cal_start),
  .park_low    (park_low),
  .hold_en     (hold_en),
  .se_tristate (se_tristate),
  .diff_force  (diff_force),
  .pin_s       (pin_sync),
  .clk_lost    (clk_lost)
);

// File: tb/pll_cal_seq_tb_top.sv
module pll_cal_seq_tb_top;

  localparam int SYNC  = 2;
  localparam int LIMIT = 4;
  // {fsel, expected diff_force while in reset}
  localparam logic [2:0] FSEL_VEC [4] = '{3'b00_0, 3'b01_1, 3'b10_1, 3'b11_1};

  logic       clk = 1'b0;
  logic       pwr_good, rstcal_n, clk_valid, cal_done, lock_ind;
  logic [1:0] fsel;
  logic       cal_start, park_low, hold_en, se_tristate, diff_force;
  logic [2:0] state_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pll_cal_seq #(.SYNC_STAGES(SYNC), .LOSS_LIMIT(LIMIT)) dut_i (
    .clk, .pwr_good, .rstcal_n, .clk_valid, .cal_done, .lock_ind, .fsel,
    .cal_start, .park_low, .hold_en, .se_tristate, .diff_force, .state_o
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    bit seen;
    pwr_good = 0; rstcal_n = 0; clk_valid = 0; cal_done = 0; lock_ind = 0; fsel = 2'b00;
    tick(3);
    check(state_o == 3'd0, "R1 state in power reset", state_o, 0);
    check(se_tristate == 1'b1, "R3 tristate in reset", se_tristate, 1);

    // R4 vector walk, pin low
    pwr_good = 1;
    foreach (FSEL_VEC[i]) begin
      fsel = FSEL_VEC[i][2:1];
      tick(1);
      check(diff_force == FSEL_VEC[i][0], "R4 diff_force by fsel", diff_force, FSEL_VEC[i][0]);
    end
    check(state_o == 3'd0, "R2 held in reset by pin", state_o, 0);

    // R5 wait without reference
    rstcal_n = 1;
    tick(SYNC + 1);
    check(state_o == 3'd1, "R5 WAIT_CLK after release", state_o, 1);
    check(park_low == 1'b1, "R5 park_low in wait", park_low, 1);
    check(se_tristate == 1'b0, "R3 tristate off", se_tristate, 0);
    check(diff_force == 1'b0, "R4 no force outside reset", diff_force, 0);
    cal_done = 1; tick(1); cal_done = 0;
    tick(4);
    check(state_o == 3'd1, "R7 cal_done ignored in wait", state_o, 1);

    // R6 entry into calibration
    clk_valid = 1;
    tick(SYNC + 1);
    check(state_o == 3'd2, "R6 CALIBRATE entered", state_o, 2);
    check(cal_start == 1'b1, "R6 cal_start pulse", cal_start, 1);
    check(park_low == 1'b0, "R5 park_low off", park_low, 0);
    tick(1);
    check(cal_start == 1'b0, "R6 pulse one cycle", cal_start, 0);

    // R11 loss during calibration
    clk_valid = 0;
    tick(SYNC + 1);
    check(state_o == 3'd1, "R11 back to WAIT_CLK", state_o, 1);
    clk_valid = 1;
    tick(SYNC + 1);
    check(cal_start == 1'b1, "R6 new pulse on re-entry", cal_start, 1);

    // R7 / R8
    cal_done = 1; tick(1); cal_done = 0;
    check(state_o == 3'd3, "R7 ACQUIRE after cal_done", state_o, 3);
    lock_ind = 1; tick(1);
    check(state_o == 3'd4, "R8 LOCKED", state_o, 4);
    lock_ind = 0; tick(1);
    check(state_o == 3'd3, "R8 lock drop to ACQUIRE", state_o, 3);
    lock_ind = 1; tick(1);
    cal_done = 1; tick(1); cal_done = 0; tick(1);
    check(state_o == 3'd4, "R7 cal_done ignored in LOCKED", state_o, 4);

    // R9 short dropout
    clk_valid = 0; tick(LIMIT - 1); clk_valid = 1;
    seen = 0;
    for (int k = 0; k < 8; k++) begin
      tick(1);
      if (hold_en) seen = 1;
    end
    check(seen == 0, "R9 short loss ignored", seen, 0);
    check(state_o == 3'd4, "R9 still LOCKED", state_o, 4);

    // R9 persistent loss, exact latency
    clk_valid = 0;
    n = 0;
    while (!hold_en && n < 30) begin
      tick(1);
      n++;
    end
    check(n == SYNC + LIMIT + 1, "R9 holdover latency", n, SYNC + LIMIT + 1);
    check(state_o == 3'd5, "R12 HOLDOVER code", state_o, 5);

    // R10 return without calibration
    lock_ind = 0; clk_valid = 1;
    seen = 0;
    for (int k = 0; k < SYNC + 1; k++) begin
      tick(1);
      if (cal_start) seen = 1;
    end
    check(state_o == 3'd3, "R10 relock via ACQUIRE", state_o, 3);
    check(seen == 0, "R10 no cal_start on return", seen, 0);
    lock_ind = 1; tick(1);
    check(state_o == 3'd4, "R8 relocked", state_o, 4);

    // R2 pin reset and recalibration
    rstcal_n = 0; fsel = 2'b00;
    tick(SYNC + 1);
    check(state_o == 3'd0, "R2 pin low resets", state_o, 0);
    check(diff_force == 1'b0, "R4 fsel 00 no force", diff_force, 0);
    fsel = 2'b10; tick(1);
    check(diff_force == 1'b1, "R4 fsel 10 forces", diff_force, 1);
    rstcal_n = 1;
    tick(SYNC + 1);
    check(state_o == 3'd1, "R2 release to WAIT_CLK", state_o, 1);
    tick(1);
    check(cal_start == 1'b1, "R2 recalibration", cal_start, 1);

    // R1 loss of power and automatic calibration
    @(negedge clk); pwr_good = 0; #1;
    check(state_o == 3'd0, "R1 power loss resets", state_o, 0);
    tick(2);
    pwr_good = 1;
    tick(SYNC + 2);
    check(state_o == 3'd2, "R1 auto calibration", state_o, 2);
    check(cal_start == 1'b1, "R1 cal_start after power", cal_start, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule